// File: doc/BRIEF.md
# Three-Rotor Rotor-Cipher Core

This block enciphers one letter per request with a three-rotor electromechanical cipher model. It has five selectable rotor wirings, a fixed reflector, a ring setting for each rotor and stepping driven by turnover notches. Letters are coded 0 to 25 for A to Z. A load pulse captures the rotor type code, ring setting and start position of each slot. Each accepted key then advances the rotors and produces one cipher letter two clock edges later. The window position of each rotor is always visible, so that a display can show it.

The cipher is its own inverse. Loading the same settings and feeding the ciphertext back in returns the plaintext. No letter is ever enciphered to itself.

Top module: `enigma_core`

## Requirements
- R1: After reset all three window positions are 0 (A) and no cipher output is valid. The slots hold type codes 0, 1 and 2 (left, middle, right), and every ring setting is 0.
- R2: A load pulse stores the type codes, ring settings and start positions. The window outputs show the start positions after the next edge, and the load pulse itself produces no cipher output.
- R3: When the load pulse and a key strobe arrive in the same cycle, the load wins. The key is discarded: no cipher output follows and no rotor steps.
- R4: The right rotor advances by one before the letter is enciphered. With type codes 0,1,2, rings 0 and starts 0, five A keys give B, D, Z, G, O, and the right window reads 1 after the first key.
- R5: Every window position wraps from 25 (Z) to 0 (A).
- R6: The notch of type codes 0 to 4 sits at letters 16, 4, 21, 9 and 25 (Q, E, V, J, Z). The middle rotor steps when the right rotor is at its notch before the step. The left rotor steps only when the middle rotor is at its notch.
- R7: Double step: when the middle rotor is at its notch, a key steps both the middle rotor and the left rotor. With codes 0,1,2 and starts A,D,U, three keys give the windows ADV, AEW, BFX.
- R8: The ring setting shifts each rotor's wiring against its window. Each pass maps c to W[(c+p-r) mod 26] − (p−r) mod 26, and the return pass uses the inverse of W. With rings 1,1,1 and starts 0, five A keys give E, W, T, Y, X.
- R9: cipher_valid_o rises exactly two clock edges after the edge that accepts a key, for one cycle per key. Keys may be presented on back-to-back cycles.
- R10: The output never equals the input letter, and enciphering the ciphertext under the same settings returns the plaintext.
- R11: Type codes 0 to 4 select five different rotor wirings, and type codes 5 to 7 act as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Apply settings |
| type_l_i | input | 3 | Left rotor type code |
| type_m_i | input | 3 | Middle rotor type code |
| type_r_i | input | 3 | Right rotor type code |
| ring_l_i | input | 5 | Left ring setting |
| ring_m_i | input | 5 | Middle ring setting |
| ring_r_i | input | 5 | Right ring setting |
| start_l_i | input | 5 | Left start position |
| start_m_i | input | 5 | Middle start position |
| start_r_i | input | 5 | Right start position |
| key_valid_i | input | 1 | Key strobe |
| key_i | input | 5 | Plaintext letter |
| cipher_valid_o | output | 1 | Cipher letter valid |
| cipher_o | output | 5 | Cipher letter |
| pos_l_o | output | 5 | Left window position |
| pos_m_o | output | 5 | Middle window position |
| pos_r_o | output | 5 | Right window position |

## Verification
Loading settings and stepping on a key can land in the same cycle. The bench provokes this by raising load_i and key_valid_i together. It passes when no cipher strobe follows and the windows show exactly the new start positions. A key in the next cycle must then match a reference model that was loaded but never stepped.

The second collision is the middle rotor's own notch against the right rotor's carry. The bench checks it through the window sequence from start A,D,U.

// File: rtl/enigma_pkg.sv
package enigma_pkg;
  localparam int unsigned NUM_LETTERS = 26;
  localparam int unsigned LW          = 5;
  localparam int unsigned NUM_TYPES   = 5;
  localparam int unsigned NUM_ROTORS  = 3;
  localparam int unsigned TW          = 3;

  typedef logic [LW-1:0] letter_t;
  typedef logic [TW-1:0] rtype_t;

  localparam letter_t ROTOR_MAP [NUM_TYPES][NUM_LETTERS] = '{
    '{4,10,12,5,11,6,3,16,21,25,13,19,14,22,24,7,23,20,18,15,0,8,1,17,2,9},
    '{0,9,3,10,18,8,17,20,23,1,11,7,22,19,12,2,16,6,25,13,15,24,5,21,14,4},
    '{1,3,5,7,9,11,2,15,17,19,23,21,25,13,24,4,8,22,6,0,10,12,20,18,16,14},
    '{4,18,14,21,15,25,9,0,24,16,20,8,17,7,23,11,13,5,19,6,10,3,2,12,22,1},
    '{21,25,1,17,6,8,19,24,20,15,18,13,14,2,7,11,12,5,22,10,16,23,4,9,3,0}
  };

  localparam letter_t REFLECTOR [NUM_LETTERS] =
    '{24,17,20,7,16,18,11,3,15,23,13,6,14,10,12,8,4,1,5,25,2,22,21,9,0,19};

  localparam letter_t NOTCH_POS [NUM_TYPES] = '{16,4,21,9,25};

  function automatic letter_t fold26(input letter_t v);
    return (v >= LW'(NUM_LETTERS)) ? v - LW'(NUM_LETTERS) : v;
  endfunction

  function automatic letter_t add26(input letter_t a, input letter_t b);
    logic [LW:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= (LW+1)'(NUM_LETTERS)) s = s - (LW+1)'(NUM_LETTERS);
    return s[LW-1:0];
  endfunction

  function automatic letter_t sub26(input letter_t a, input letter_t b);
    return (a >= b) ? a - b : a + LW'(NUM_LETTERS) - b;
  endfunction

  function automatic rtype_t type_fold(input rtype_t c);
    return (c < TW'(NUM_TYPES)) ? c : '0;
  endfunction

  function automatic letter_t rotor_inv(input rtype_t t, input letter_t c);
    letter_t r;
    r = '0;
    for (int j = 0; j < NUM_LETTERS; j++)
      if (ROTOR_MAP[t][j] == c) r = LW'(j);
    return r;
  endfunction
endpackage

// File: rtl/enigma_stepper.sv
module enigma_stepper import enigma_pkg::*; (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    step_i,
  input  logic    load_i,
  input  letter_t notch_i [NUM_ROTORS],
  input  letter_t start_i [NUM_ROTORS],
  output letter_t pos_o   [NUM_ROTORS]
);
  letter_t pos_q [NUM_ROTORS];
  logic [NUM_ROTORS-1:0] adv;

  // index 0 = right, 1 = middle, 2 = left
  always_comb begin
    adv[0] = 1'b1;
    adv[1] = (pos_q[0] == notch_i[0]) || (pos_q[1] == notch_i[1]);
    adv[2] = (pos_q[1] == notch_i[1]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_ROTORS; i++) pos_q[i] <= '0;
    end else if (load_i) begin
      for (int i = 0; i < NUM_ROTORS; i++) pos_q[i] <= start_i[i];
    end else if (step_i) begin
      for (int i = 0; i < NUM_ROTORS; i++)
        if (adv[i]) pos_q[i] <= add26(pos_q[i], LW'(1));
    end
  end

  assign pos_o = pos_q;

  assert_right_adv_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && pos_q[0] != LW'(25)) |=> pos_q[0] == $past(pos_q[0]) + LW'(1));
  assert_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && pos_q[0] == LW'(25)) |=> pos_q[0] == '0);
  assert_left_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && pos_q[1] != notch_i[1]) |=> pos_q[2] == $past(pos_q[2]));
  assert_double_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && pos_q[1] == notch_i[1]) |=>
      (pos_q[1] != $past(pos_q[1])) && (pos_q[2] != $past(pos_q[2])));
  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (pos_q[0] == $past(start_i[0])) && (pos_q[1] == $past(start_i[1]))
               && (pos_q[2] == $past(start_i[2])));
endmodule

// File: rtl/enigma_rotor.sv
module enigma_rotor import enigma_pkg::*; #(
  parameter bit INVERSE = 1'b0
) (
  input  rtype_t  type_i,
  input  letter_t ring_i,
  input  letter_t pos_i,
  input  letter_t in_i,
  output letter_t out_o
);
  letter_t off, idx, wired;

  assign off = sub26(pos_i, ring_i);
  assign idx = add26(in_i, off);

  if (INVERSE) begin : g_inv
    assign wired = rotor_inv(type_i, idx);
  end else begin : g_fwd
    assign wired = ROTOR_MAP[type_i][idx];
  end

  assign out_o = sub26(wired, off);
endmodule

// File: rtl/enigma_core.sv
module enigma_core import enigma_pkg::*; (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] type_l_i,
  input  logic [TW-1:0] type_m_i,
  input  logic [TW-1:0] type_r_i,
  input  logic [LW-1:0] ring_l_i,
  input  logic [LW-1:0] ring_m_i,
  input  logic [LW-1:0] ring_r_i,
  input  logic [LW-1:0] start_l_i,
  input  logic [LW-1:0] start_m_i,
  input  logic [LW-1:0] start_r_i,
  input  logic          key_valid_i,
  input  logic [LW-1:0] key_i,
  output logic          cipher_valid_o,
  output logic [LW-1:0] cipher_o,
  output logic [LW-1:0] pos_l_o,
  output logic [LW-1:0] pos_m_o,
  output logic [LW-1:0] pos_r_o
);
  logic    accept, pend_q, valid_q;
  letter_t key_q, cipher_q;
  rtype_t  type_in [NUM_ROTORS];
  rtype_t  type_q  [NUM_ROTORS];
  letter_t ring_in [NUM_ROTORS];
  letter_t ring_q  [NUM_ROTORS];
  letter_t start_in[NUM_ROTORS];
  letter_t start_s [NUM_ROTORS];
  letter_t notch_s [NUM_ROTORS];
  letter_t pos     [NUM_ROTORS];
  letter_t fwd     [NUM_ROTORS+1];
  letter_t back    [NUM_ROTORS+1];

  assign type_in  = '{type_r_i, type_m_i, type_l_i};
  assign ring_in  = '{ring_r_i, ring_m_i, ring_l_i};
  assign start_in = '{start_r_i, start_m_i, start_l_i};

  // load beats key in the same cycle
  assign accept = key_valid_i && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      type_q[0] <= TW'(2);
      type_q[1] <= TW'(1);
      type_q[2] <= '0;
      for (int i = 0; i < NUM_ROTORS; i++) ring_q[i] <= '0;
    end else if (load_i) begin
      for (int i = 0; i < NUM_ROTORS; i++) begin
        type_q[i] <= type_fold(type_in[i]);
        ring_q[i] <= fold26(ring_in[i]);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      key_q    <= '0;
      valid_q  <= 1'b0;
      cipher_q <= '0;
    end else begin
      pend_q  <= accept;
      valid_q <= pend_q;
      if (accept) key_q <= fold26(key_i);
      if (pend_q) cipher_q <= back[0];
    end
  end

  enigma_stepper u_stepper (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (accept),
    .load_i  (load_i),
    .notch_i (notch_s),
    .start_i (start_s),
    .pos_o   (pos)
  );

  assign fwd[0] = key_q;
  assign back[NUM_ROTORS] = REFLECTOR[fwd[NUM_ROTORS]];

  for (genvar g = 0; g < NUM_ROTORS; g++) begin : g_slot
    assign start_s[g] = fold26(start_in[g]);
    assign notch_s[g] = NOTCH_POS[type_q[g]];

    enigma_rotor #(.INVERSE(1'b0)) u_fwd (
      .type_i (type_q[g]),
      .ring_i (ring_q[g]),
      .pos_i  (pos[g]),
      .in_i   (fwd[g]),
      .out_o  (fwd[g+1])
    );

    enigma_rotor #(.INVERSE(1'b1)) u_inv (
      .type_i (type_q[g]),
      .ring_i (ring_q[g]),
      .pos_i  (pos[g]),
      .in_i   (back[g+1]),
      .out_o  (back[g])
    );
  end

  assign cipher_valid_o = valid_q;
  assign cipher_o       = cipher_q;
  assign pos_r_o        = pos[0];
  assign pos_m_o        = pos[1];
  assign pos_l_o        = pos[2];

  assert_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> ##1 cipher_valid_o);
  assert_load_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ##1 !cipher_valid_o);
  assert_no_self_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cipher_valid_o |-> cipher_o != $past(key_q));
  assert_pos_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_l_o < LW'(NUM_LETTERS)) && (pos_m_o < LW'(NUM_LETTERS)) && (pos_r_o < LW'(NUM_LETTERS)));
endmodule

// File: tb/enigma_core_tb.sv
module enigma_core_tb;
  logic clk = 1'b0, rst_n = 1'b0, load = 1'b0, key_valid = 1'b0;
  logic [2:0] t_l = 0, t_m = 0, t_r = 0;
  logic [4:0] r_l = 0, r_m = 0, r_r = 0, s_l = 0, s_m = 0, s_r = 0, key = 0;
  logic cv;
  logic [4:0] co, p_l, p_m, p_r;
  int n_cmp = 0, n_bad = 0;

  string rot_tab [5] = '{"EKMFLGDQVZNTOWYHXUSPAIBRCJ", "AJDKSIRUXBLHWTMCQGZNPYFVOE",
                         "BDFHJLCPRTXVZNYEIWGAKMUSQO", "ESOVPZJAYQUIRHXLNFTGKDCMWB",
                         "VZBRGITYUPSNOCHLMFWKQXEJDA"};
  string refl_tab = "YRUHQSLDPXNGOKMIEBFZCWVJAT";
  string notch_tab = "QEVJZ";
  int mpos [3], mtype [3], mring [3];   // 0 right, 1 middle, 2 left

  // rows: ring (all slots), key, expected; rows 0 and 5 reload
  localparam int VEC [10][3] = '{
    '{0,0,1}, '{0,0,3}, '{0,0,25}, '{0,0,6}, '{0,0,14},
    '{1,0,4}, '{1,0,22}, '{1,0,19}, '{1,0,24}, '{1,0,23}};

  always #2 clk = ~clk;   // 4 ns period

  enigma_core u_dut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load),
    .type_l_i(t_l), .type_m_i(t_m), .type_r_i(t_r),
    .ring_l_i(r_l), .ring_m_i(r_m), .ring_r_i(r_r),
    .start_l_i(s_l), .start_m_i(s_m), .start_r_i(s_r),
    .key_valid_i(key_valid), .key_i(key),
    .cipher_valid_o(cv), .cipher_o(co),
    .pos_l_o(p_l), .pos_m_o(p_m), .pos_r_o(p_r));

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nidx(input int t);
    return notch_tab[t] - 65;
  endfunction

  function automatic int pass_f(input int t, input int r, input int p, input int c);
    int off = (p - r + 26) % 26;
    return (rot_tab[t][(c + off) % 26] - 65 - off + 26) % 26;
  endfunction

  function automatic int pass_b(input int t, input int r, input int p, input int c);
    int off = (p - r + 26) % 26;
    int x = (c + off) % 26;
    int j0 = 0;
    for (int j = 0; j < 26; j++) if (rot_tab[t][j] - 65 == x) j0 = j;
    return (j0 - off + 26) % 26;
  endfunction

  task automatic model_key(input int c, output int o);
    int v;
    if (mpos[1] == nidx(mtype[1])) begin
      mpos[1] = (mpos[1] + 1) % 26;
      mpos[2] = (mpos[2] + 1) % 26;
    end else if (mpos[0] == nidx(mtype[0])) mpos[1] = (mpos[1] + 1) % 26;
    mpos[0] = (mpos[0] + 1) % 26;
    v = c;
    for (int i = 0; i < 3; i++) v = pass_f(mtype[i], mring[i], mpos[i], v);
    v = refl_tab[v] - 65;
    for (int i = 2; i >= 0; i--) v = pass_b(mtype[i], mring[i], mpos[i], v);
    o = v;
  endtask

  task automatic do_load(input int tl, input int tm, input int tr, input int rl, input int rm,
                         input int rr, input int sl, input int sm, input int sr, input bit with_key);
    @(negedge clk);
    t_l = 3'(tl); t_m = 3'(tm); t_r = 3'(tr);
    r_l = 5'(rl); r_m = 5'(rm); r_r = 5'(rr);
    s_l = 5'(sl); s_m = 5'(sm); s_r = 5'(sr);
    load = 1'b1; key_valid = with_key; key = 5'd0;
    @(negedge clk);
    load = 1'b0; key_valid = 1'b0;
    mtype = '{(tr > 4) ? 0 : tr, (tm > 4) ? 0 : tm, (tl > 4) ? 0 : tl};
    mring = '{rr, rm, rl};
    mpos  = '{sr, sm, sl};
  endtask

  task automatic key_once(input int c, output int o, output int v);
    @(negedge clk);
    key = 5'(c); key_valid = 1'b1;
    @(negedge clk);
    key_valid = 1'b0;
    @(negedge clk);
    v = cv; o = co;
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int o, v, e;
    int plain [5], ciph [5];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state and default types/rings: A key at positions AAA gives B
    chk("R1 valid", cv, 0);
    chk("R1 pos", {p_l, p_m, p_r}, 0);
    key_once(0, o, v);
    chk("R1 default cipher", o, 1);

    // vector table: R4 and R8
    for (int i = 0; i < 10; i++) begin
      if (i % 5 == 0) do_load(0, 1, 2, VEC[i][0], VEC[i][0], VEC[i][0], 0, 0, 0, 1'b0);
      key_once(VEC[i][1], o, v);
      chk(VEC[i][0] == 0 ? "R4 vector" : "R8 ring vector", o, VEC[i][2]);
      chk("R9 valid", v, 1);
      if (i == 0) chk("R4 right window", p_r, 1);
    end

    // R2 load shows start positions, no output
    do_load(3, 4, 0, 2, 3, 4, 7, 8, 9, 1'b0);
    chk("R2 valid after load", cv, 0);
    chk("R2 left", p_l, 7); chk("R2 mid", p_m, 8); chk("R2 right", p_r, 9);

    // R7 double step ADU
    do_load(0, 1, 2, 0, 0, 0, 0, 3, 20, 1'b0);
    key_once(4, o, v); chk("R7 step1", {p_l, p_m, p_r}, {5'd0, 5'd3, 5'd21});
    key_once(4, o, v); chk("R7 step2", {p_l, p_m, p_r}, {5'd0, 5'd4, 5'd22});
    key_once(4, o, v); chk("R7 step3", {p_l, p_m, p_r}, {5'd1, 5'd5, 5'd23});

    // R5/R6 wrap with type code 4 (notch Z) on the right
    do_load(0, 1, 4, 0, 0, 0, 0, 0, 25, 1'b0);
    key_once(0, o, v);
    chk("R5 wrap right", p_r, 0);
    chk("R6 middle carry", p_m, 1);
    chk("R6 left held", p_l, 0);

    // R3 load and key together
    do_load(0, 1, 2, 0, 0, 0, 0, 0, 5, 1'b1);
    chk("R3 no strobe", cv, 0);
    @(negedge clk);
    chk("R3 no strobe later", cv, 0);
    chk("R3 no step", p_r, 5);
    key_once(2, o, v); model_key(2, e);
    chk("R3 next key", o, e);

    // R9 latency and back-to-back keys
    do_load(1, 3, 0, 4, 5, 6, 10, 11, 12, 1'b0);
    @(negedge clk); key = 5'd3; key_valid = 1'b1;
    @(negedge clk); key = 5'd9; chk("R9 not yet", cv, 0);
    @(negedge clk); key = 5'd17; model_key(3, e); chk("R9 b2b 0", co, e); chk("R9 strobe", cv, 1);
    @(negedge clk); key_valid = 1'b0; model_key(9, e); chk("R9 b2b 1", co, e);
    @(negedge clk); model_key(17, e); chk("R9 b2b 2", co, e);
    @(negedge clk); chk("R9 strobe ends", cv, 0);

    // R10 reciprocity and no self-map
    plain = '{7, 4, 11, 11, 14};
    do_load(3, 0, 4, 3, 7, 11, 10, 20, 8, 1'b0);
    for (int i = 0; i < 5; i++) begin
      key_once(plain[i], o, v); ciph[i] = o;
      if (o == plain[i]) chk("R10 self map", o, 99);
    end
    do_load(3, 0, 4, 3, 7, 11, 10, 20, 8, 1'b0);
    for (int i = 0; i < 5; i++) begin
      key_once(ciph[i], o, v); chk("R10 decrypt", o, plain[i]);
    end

    // R11 out-of-range code acts as code 0
    do_load(6, 7, 5, 0, 0, 0, 0, 0, 0, 1'b0);
    for (int i = 0; i < 4; i++) begin
      key_once(i, o, v); model_key(i, e); chk("R11 code fold", o, e);
    end

    // R11/R6 sweep against model, mid at its notch
    do_load(3, 4, 1, 5, 12, 25, 24, 25, 2, 1'b0);
    for (int i = 0; i < 40; i++) begin
      key_once((i * 7 + 3) % 26, o, v); model_key((i * 7 + 3) % 26, e);
      chk("R11 sweep", o, e);
      chk("R6 sweep windows", {p_l, p_m, p_r}, {5'(mpos[2]), 5'(mpos[1]), 5'(mpos[0])});
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule